// File: doc/BRIEF.md
# Time-Multiplexed Systolic FIR Filter Array

This block computes FIR filter outputs with a fixed row of sixteen multiply-accumulate stages. Each stage is reused 1, 2, 4 or 8 times for every input sample. The reuse factor trades processing cycles per sample against filter length, so a single filter has 16 to 128 taps. The array works in one of three ways. It can be one long filter. It can be two half-length filters on separate inputs. It can be two half-length filters where the second filters the mid-scale slice of the first one's output. An optional decimate-by-two setting produces one output for every two inputs and doubles the number of taps each stage handles.

Input samples enter through a valid/ready stream. When `in_valid` and `in_ready` are both high at a rising clock edge, the block takes one sample (`in_a`, `in_b`, `in_x`). `in_ready` is high only while the array is idle. It stays low while the stages compute and while a result waits to be taken. Results leave through a second valid/ready stream. Once `out_valid` rises, `res_a` and `res_b` hold their values until a clock edge where `out_ready` is high. Because of this, back-pressure on the output stops intake of new samples.

Coefficients come from an outside RAM. The block exposes one combinational read port per stage, and the configuration word is static between resets.

Top module: `systolic_fir_mc`

## Requirements
- R1: A sample is taken only on an edge with `in_valid` and `in_ready` both high. `in_ready` and `out_valid` are never high together. After a result is taken, `in_ready` is high on the next cycle.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `res_a` and `res_b` keep their values.
- R3: `cfg[14:13]` sets the reuse factor F: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8. Each stage handles T = F taps, or 2F taps when decimating. `out_valid` rises exactly T cycles after the sample that starts a computation is taken.
- R4: Single mode is selected by `cfg[15]`=1. The k-th result is ypartial(k−15), where y(n) = Σ_{j<16T} c(j)·a(n−j). Here c(j) is the coefficient at address j reduced to its upper 12 bits (`coef[15:4]`, signed). Samples before the first one count as zero, so the first 15 results are zero.
- R5: Stage s reads address s·T + p in compute phase p. Its address therefore always lies in [s·T, s·T+T).
- R6: `cfg[12]`=1 selects decimate-by-two, except in series mode. One result is produced per two samples. Result m equals the filter sum at input index 2(m−15)+1 in single mode, or 2(m−7)+1 in the dual modes. Single mode then has 32F taps.
- R7: Independent dual mode is selected by `cfg[15]`=0 and `cfg[4]`=0. Network A filters `in_a` into `res_a` using addresses 0..8T−1. Network B filters `in_b` into `res_b` using addresses 8T..16T−1. Each network has a latency of 7 results.
- R8: Series mode is selected by `cfg[15]`=0 and `cfg[4]`=1. Network B's sample for input n is bits [23:8] of network A's result for input n−1, with zero for n=0. Decimation is ignored in this mode.
- R9: In single mode with `x_en`=1, the `in_x` value taken with a sample is added to the result that sample indexes. With `x_en`=0, or in either dual mode, `in_x` has no effect.
- R10: Sums wrap in 32-bit two's complement and never saturate.
- R11: In single mode, after the n-th sample is taken, `dly_out` shows the sample taken 16T samples earlier, or zero if there is none. In the dual modes `dly_out` is zero.
- R12: After reset, `in_ready`=1, `out_valid`=0 and `dly_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg | input | 16 | Mode word: [15] single, [14:13] reuse, [12] decimate, [4] series |
| x_en | input | 1 | Use the expansion input (single mode) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_a | input | 16 | Sample for network A / single filter |
| in_b | input | 16 | Sample for network B (independent dual) |
| in_x | input | 32 | Partial sum from an upstream array |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| res_a | output | 32 | Single or network A result |
| res_b | output | 32 | Network B result, zero in single mode |
| dly_out | output | 16 | Delayed sample for a downstream array |
| coef_addr | output | 128 | Per-stage coefficient address, 8 bits each |
| coef_data | input | 256 | Per-stage coefficient word, 16 bits each |

## Verification
The bench covers each reuse factor, both decimation parities, the two dual arrangements and the widest 256-tap decimating filter. Each of these paths fails in its own way:
- A tap-index or hand-over error shows up as wrong values once the window fills.
- A decimator that fires on the wrong sample of a pair shifts every result by one input.
- A series link that takes the wrong bit slice, or the current instead of the previous A result, breaks network B.

The bench also drives a constant worst-case stream with a large expansion term, which exposes saturating or narrow accumulators. It uses random output stalls and sends nonzero `in_x` where that input must be ignored.

// File: rtl/fir_mc_pkg.sv
package fir_mc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_OUT
  } seq_state_e;

  typedef struct packed {
    logic       single;
    logic       series;
    logic       dec;
    logic [1:0] reuse_sel;
  } mode_t;

  // Mode word decode; series mode forbids decimation.
  function automatic mode_t decode_cfg(input logic [15:0] w);
    mode_t m;
    m.single    = w[15];
    m.series    = !w[15] && w[4];
    m.dec       = w[12] && !m.series;
    m.reuse_sel = w[14:13];
    return m;
  endfunction

endpackage

// File: rtl/fir_mc_seq.sv
module fir_mc_seq
  import fir_mc_pkg::*;
#(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic [TW-1:0] tps,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          accept,
  output logic          run,
  output logic          first,
  output logic          last,
  output logic [TW-1:0] phase
);

  seq_state_e st;
  logic       pair_odd;

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_OUT);
  assign accept    = in_valid && in_ready;
  assign run       = (st == ST_RUN);
  assign first     = run && (phase == '0);
  assign last      = run && (phase == tps - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      phase    <= '0;
      pair_odd <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (!dec || pair_odd) begin
              st    <= ST_RUN;
              phase <= '0;
            end
            pair_odd <= dec ? ~pair_odd : 1'b0;
          end
        end
        ST_RUN: begin
          if (last) begin
            st    <= ST_OUT;
            phase <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_OUT: begin
          if (out_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fir_mc_hist.sv
module fir_mc_hist #(
  parameter int DW    = 16,
  parameter int DEPTH = 286
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift,
  input  logic [DW-1:0]              din,
  output logic [DEPTH-1:0][DW-1:0]   taps
);

  // Entry 0 is the newest sample.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift) begin
      taps <= {taps[DEPTH-2:0], din};
    end
  end

endmodule

// File: rtl/fir_mc_mac.sv
module fir_mc_mac #(
  parameter int DW   = 16,
  parameter int CW   = 12,
  parameter int ACCW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            first,
  input  logic            last,
  input  logic [DW-1:0]   din,
  input  logic [DW-1:0]   coef,
  input  logic [ACCW-1:0] chain_in,
  output logic [ACCW-1:0] chain_out
);

  logic signed [CW-1:0]    c_red;
  logic signed [DW+CW-1:0] prod;
  logic signed [ACCW-1:0]  prod_x;
  logic [ACCW-1:0]         loc;
  logic                    coef_unused;

  assign c_red       = coef[DW-1 -: CW];
  assign coef_unused = ^coef[DW-CW-1:0];
  assign prod        = $signed(din) * c_red;
  assign prod_x      = ACCW'(prod);

  // Local sum over the phases, handed on with the upstream sum at the last phase.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc       <= '0;
      chain_out <= '0;
    end else if (run) begin
      if (first) loc <= prod_x;
      else       loc <= loc + prod_x;
      if (last)  chain_out <= chain_in + (first ? '0 : loc) + prod_x;
    end
  end

endmodule

// File: rtl/systolic_fir_mc.sv
module systolic_fir_mc
  import fir_mc_pkg::*;
#(
  parameter int STAGES    = 16,
  parameter int MAX_REUSE = 8,
  parameter int DW        = 16,
  parameter int CW        = 12,
  parameter int ACCW      = 32,
  parameter int CA        = $clog2(STAGES * 2 * MAX_REUSE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cfg,
  input  logic                 x_en,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_a,
  input  logic [DW-1:0]        in_b,
  input  logic [ACCW-1:0]      in_x,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ACCW-1:0]      res_a,
  output logic [ACCW-1:0]      res_b,
  output logic [DW-1:0]        dly_out,
  output logic [STAGES*CA-1:0] coef_addr,
  input  logic [STAGES*DW-1:0] coef_data
);

  localparam int HALF   = STAGES / 2;
  localparam int MAXTPS = 2 * MAX_REUSE;
  localparam int TW     = $clog2(MAXTPS) + 1;
  localparam int DEPTH  = STAGES * MAXTPS + 2 * (STAGES - 1);
  localparam int IW     = $clog2(DEPTH + 1);
  localparam int MID_LO = (ACCW - DW) / 2;

  mode_t           md;
  logic [TW-1:0]   reuse;
  logic [TW-1:0]   tps;
  logic [1:0]      step;
  logic            cfg_unused;

  assign md         = decode_cfg(cfg);
  assign reuse      = TW'(1) << md.reuse_sel;
  assign tps        = md.dec ? (reuse << 1) : reuse;
  assign step       = md.dec ? 2'd2 : 2'd1;
  assign cfg_unused = ^{cfg[11:5], cfg[3:0]};

  logic          accept, run, first, last;
  logic [TW-1:0] phase;

  fir_mc_seq #(.TW(TW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (md.dec),
    .tps       (tps),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .accept    (accept),
    .run       (run),
    .first     (first),
    .last      (last),
    .phase     (phase)
  );

  logic [STAGES-1:0][ACCW-1:0] chain;
  logic [DEPTH-1:0][DW-1:0]    hist_a;
  logic [DEPTH-1:0][DW-1:0]    hist_b;
  logic [DW-1:0]               din_b;
  logic [ACCW-1:0]             xcap;

  // Series mode feeds network B with the mid slice of network A's last result.
  assign din_b = md.series ? chain[HALF-1][MID_LO +: DW] : in_b;

  fir_mc_hist #(.DW(DW), .DEPTH(DEPTH)) u_hist_a (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (accept),
    .din   (in_a),
    .taps  (hist_a)
  );

  fir_mc_hist #(.DW(DW), .DEPTH(DEPTH)) u_hist_b (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (accept),
    .din   (din_b),
    .taps  (hist_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      xcap <= '0;
    else if (accept) xcap <= (md.single && x_en) ? in_x : '0;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int LOC = s % HALF;
    logic [IW-1:0]   idx;
    logic [DW-1:0]   dsel;
    logic [ACCW-1:0] prev;

    // History offset: tap index plus one step per stage of hand-over delay.
    always_comb begin
      int pos;
      pos = (md.single ? s : LOC) * (int'(tps) + int'(step)) + int'(phase);
      idx = IW'(pos);
    end

    if (s < HALF) begin : g_src_a
      assign dsel = hist_a[idx];
    end else begin : g_src_ab
      assign dsel = md.single ? hist_a[idx] : hist_b[idx];
    end

    if (s == 0) begin : g_head
      assign prev = xcap;
    end else if (s == HALF) begin : g_mid
      assign prev = md.single ? chain[s-1] : '0;
    end else begin : g_link
      assign prev = chain[s-1];
    end

    assign coef_addr[s*CA +: CA] = CA'(s) * CA'(tps) + CA'(phase);

    fir_mc_mac #(.DW(DW), .CW(CW), .ACCW(ACCW)) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .first     (first),
      .last      (last),
      .din       (dsel),
      .coef      (coef_data[s*DW +: DW]),
      .chain_in  (prev),
      .chain_out (chain[s])
    );
  end

  logic [IW-1:0] nidx;
  assign nidx    = IW'(STAGES * int'(tps));
  assign dly_out = md.single ? hist_a[nidx] : '0;

  assign res_a = md.single ? chain[STAGES-1] : chain[HALF-1];
  assign res_b = md.single ? '0 : chain[STAGES-1];

endmodule

// File: rtl/fir_mc_chk.sv
module fir_mc_chk #(
  parameter int STAGES = 16,
  parameter int CA     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [15:0]          cfg,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [31:0]          res_a,
  input logic [31:0]          res_b,
  input logic [STAGES*CA-1:0] coef_addr
);

  logic       series_c, dec_c;
  logic [4:0] tps_c;
  logic [5:0] cnt;

  assign series_c = !cfg[15] && cfg[4];
  assign dec_c    = cfg[12] && !series_c;
  assign tps_c    = dec_c ? (5'd2 << cfg[14:13]) : (5'd1 << cfg[14:13]);

  always_ff @(posedge clk) begin
    if (!rst_n)                           cnt <= '0;
    else if (in_valid && in_ready)        cnt <= '0;
    else if (!out_valid && cnt != 6'h3f)  cnt <= cnt + 1'b1;
  end

  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_ready_after_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_a) && $stable(res_b)));

  p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (cnt == 6'(tps_c)));

  for (genvar s = 0; s < STAGES; s++) begin : g_win
    p_coef_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(coef_addr[s*CA +: CA]) >= s * int'(tps_c)) &&
      (int'(coef_addr[s*CA +: CA]) < (s + 1) * int'(tps_c)));
  end

endmodule

bind systolic_fir_mc fir_mc_chk #(.STAGES(STAGES), .CA(CA)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg       (cfg),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .res_a     (res_a),
  .res_b     (res_b),
  .coef_addr (coef_addr)
);

// File: tb/systolic_fir_mc_bench.sv
module systolic_fir_mc_bench;

  localparam int STAGES = 16;
  localparam int DW     = 16;
  localparam int CA     = 8;
  localparam int MAXK   = 320;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic [15:0]          cfg = 16'h8000;
  logic                 x_en = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [15:0]          in_a = '0;
  logic [15:0]          in_b = '0;
  logic [31:0]          in_x = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b0;
  logic [31:0]          res_a, res_b;
  logic [15:0]          dly_out;
  logic [STAGES*CA-1:0] coef_addr;
  logic [STAGES*DW-1:0] coef_data;

  logic [15:0] cram [256];

  always_comb begin
    for (int s = 0; s < STAGES; s++)
      coef_data[s*DW +: DW] = cram[coef_addr[s*CA +: CA]];
  end

  systolic_fir_mc u_systolic_fir_mc (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .x_en(x_en),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_x(in_x),
    .out_valid(out_valid), .out_ready(out_ready),
    .res_a(res_a), .res_b(res_b), .dly_out(dly_out),
    .coef_addr(coef_addr), .coef_data(coef_data)
  );

  int          xa [MAXK];
  int          xb [MAXK];
  int          xe [MAXK];
  int          u  [MAXK];
  logic [31:0] ua [MAXK];
  logic [63:0] exp_q [$];
  string       cur_req = "R12";
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] drv_lfsr = 32'h1234_5678;
  logic [31:0] mon_lfsr = 32'h0bad_cafe;
  bit          bp_heavy = 1'b0;

  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] r;
    r = v ^ (v << 13);
    r = r ^ (r >> 17);
    r = r ^ (r << 5);
    return r;
  endfunction

  function automatic int c12(input int k);
    logic signed [11:0] c;
    c = $signed(cram[k][15:4]);
    return int'(c);
  endfunction

  function automatic logic [31:0] net_val(input int base, input int ntaps,
                                          input int src, input int idx, input bit addx);
    longint acc;
    acc = 0;
    for (int k = 0; k < ntaps; k++) begin
      int j;
      int v;
      j = idx - k;
      if (j >= 0) begin
        v = (src == 0) ? xa[j] : ((src == 1) ? xb[j] : u[j]);
        acc += longint'(c12(base + k)) * longint'(v);
      end
    end
    if (addx) acc += longint'(xe[idx]);
    return 32'(acc);
  endfunction

  // Monitor: picks out_ready, then compares each transfer with the scoreboard.
  always @(negedge clk) begin
    mon_lfsr = nxt(mon_lfsr);
    out_ready = bp_heavy ? mon_lfsr[0] : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1 (%s): unexpected result a=%h b=%h, expected none", cur_req, res_a, res_b);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        if ({res_a, res_b} !== e) begin
          n_bad++;
          $display("FAIL %s: got a=%h b=%h expected a=%h b=%h",
                   cur_req, res_a, res_b, e[63:32], e[31:0]);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic run_case(input string req, input logic [15:0] c, input bit xe_on,
                          input int k, input bit wrap, input bit heavy);
    bit single, series, dec;
    int f, t, nout, lat, ntap;
    single = c[15];
    series = !c[15] && c[4];
    dec    = c[12] && !series;
    f      = 1 << c[14:13];
    t      = dec ? 2 * f : f;
    cur_req = req;
    for (int i = 0; i < 256; i++) begin
      drv_lfsr = nxt(drv_lfsr);
      cram[i] = wrap ? 16'h8000 : drv_lfsr[15:0];
    end
    for (int n = 0; n < k; n++) begin
      logic signed [15:0] sa, sb;
      drv_lfsr = nxt(drv_lfsr);
      sa = wrap ? 16'sh8000 : drv_lfsr[15:0];
      sb = drv_lfsr[31:16];
      xa[n] = int'(sa);
      xb[n] = int'(sb);
      drv_lfsr = nxt(drv_lfsr);
      xe[n] = wrap ? 32'h7fff_ffff : int'(drv_lfsr);
    end
    exp_q.delete();
    lat  = single ? 15 : 7;
    ntap = single ? 16 * t : 8 * t;
    nout = dec ? k / 2 : k;
    if (series) begin
      for (int n = 0; n < k; n++) begin
        logic signed [15:0] mid;
        ua[n] = (n < 7) ? 32'h0 : net_val(0, ntap, 0, n - 7, 1'b0);
        if (n == 0) u[n] = 0;
        else begin
          mid = ua[n-1][23:8];
          u[n] = int'(mid);
        end
      end
      for (int n = 0; n < k; n++) begin
        logic [31:0] b;
        b = (n < 7) ? 32'h0 : net_val(8 * t, ntap, 2, n - 7, 1'b0);
        exp_q.push_back({ua[n], b});
      end
    end else begin
      for (int m = 0; m < nout; m++) begin
        logic [31:0] a, b;
        int idx;
        idx = dec ? 2 * (m - lat) + 1 : m - lat;
        if (m < lat) begin
          a = 0;
          b = 0;
        end else if (single) begin
          a = net_val(0, ntap, 0, idx, xe_on);
          b = 0;
        end else begin
          a = net_val(0, ntap, 0, idx, 1'b0);
          b = net_val(8 * t, ntap, 1, idx, 1'b0);
        end
        exp_q.push_back({a, b});
      end
    end
    // Reset with the new mode word.
    @(negedge clk);
    rst_n = 1'b0;
    bp_heavy = heavy;
    cfg = c;
    x_en = xe_on;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R12 in_ready", 32'(in_ready), 32'h1);
    check("R12 out_valid", 32'(out_valid), 32'h0);
    check("R12 dly_out", 32'(dly_out), 32'h0);
    // Drive samples.
    for (int n = 0; n < k; n++) begin
      logic [15:0] dexp;
      in_valid = 1'b1;
      in_a = xa[n][15:0];
      in_b = xb[n][15:0];
      in_x = xe[n];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      dexp = (single && n >= 16 * t) ? xa[n - 16 * t][15:0] : 16'h0;
      check("R11 dly_out", 32'(dly_out), 32'(dexp));
      drv_lfsr = nxt(drv_lfsr);
      if (drv_lfsr[1:0] == 2'b00) @(negedge clk);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R1: watchdog expired, pending results %0d expected 0", exp_q.size());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run_case("R4 single F=1",            16'h8000, 1'b0, 40,  1'b0, 1'b0);
    run_case("R9 single F=2 expansion",  16'ha000, 1'b1, 60,  1'b0, 1'b0);
    run_case("R3 R2 single F=4 stalls",  16'hc000, 1'b0, 80,  1'b0, 1'b1);
    run_case("R10 wrap F=8",             16'he000, 1'b1, 160, 1'b1, 1'b0);
    run_case("R6 decimate F=2",          16'hb000, 1'b1, 80,  1'b0, 1'b1);
    run_case("R7 R9 dual independent",   16'h2000, 1'b1, 60,  1'b0, 1'b0);
    run_case("R8 series, dec ignored",   16'h1010, 1'b0, 60,  1'b0, 1'b1);
    run_case("R5 dual decimate F=4",     16'h5000, 1'b0, 120, 1'b0, 1'b0);
    run_case("R6 decimate F=8 256 taps", 16'hf000, 1'b0, 300, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule